// File: doc/BRIEF.md
# Control-Transfer Resolution Unit

This unit sits in the execute stage of a 32-bit integer pipeline and handles every instruction that can change the flow of control. It receives one instruction word per cycle with a valid strobe, the address that instruction was fetched from, and the two source operand values read from the register file. It recognises conditional branches, the direct jump-and-link and the register-indirect jump-and-link. For each of these it decides whether control moves and computes where it goes. For the two jumps it also computes the return address.

All results are registered and appear one cycle after the strobe. A taken transfer to an address that is not word aligned becomes a fetch-misalignment fault instead of a redirect, unless the core is built with 16-bit instruction support (parameter `HAS_COMPRESSED`). A branch that falls through is never checked for alignment. Instruction fetch, prediction and register-file storage are outside the block.

Top module: `ctl_xfer_resolve`

## Requirements
- R1: While `rst_ni` is low, and in the first cycle after it rises, `redirect_o`, `wr_en_o` and `fault_o` are 0.
- R2: Opcode 1100011 is a conditional branch, and funct3 (bits 14:12) selects the condition: 000 equal, 001 not equal, 100 signed less-than, 101 signed greater-or-equal, 110 unsigned less-than, 111 unsigned greater-or-equal, comparing operand A against operand B.
- R3: The branch offset is sign-extended from 13 bits with bit 0 zero. Offset bit 12 comes from instruction bit 31, bit 11 from bit 7, bits 10:5 from bits 30:25 and bits 4:1 from bits 11:8. The target is the PC plus this offset.
- R4: Opcode 1101111 is a direct jump. Its offset is sign-extended from 21 bits with bit 0 zero. Offset bit 20 comes from instruction bit 31, bits 19:12 from bits 19:12, bit 11 from bit 20 and bits 10:1 from bits 30:21. The target is the PC plus this offset.
- R5: Opcode 1100111 with funct3 000 is an indirect jump. The target is operand A plus the sign-extended 12-bit field in bits 31:20, with bit 0 of the sum cleared.
- R6: A jump that does not fault writes PC+4 to the destination index in bits 11:7: `wr_en_o` is 1, `wr_idx_o` is that index and `wr_data_o` is PC+4.
- R7: A destination index of 0 never produces `wr_en_o`. The redirect still happens.
- R8: With `HAS_COMPRESSED`=0, a taken transfer whose target has bit 1 set raises `fault_o` and places the target on `fault_addr_o`. It gives no redirect and no register write. A taken transfer without this fault gives `redirect_o` with the target on `target_o`.
- R9: A branch whose condition is false gives no redirect, no write and no fault, even when its target would be misaligned.
- R10: Any other opcode, a branch funct3 of 010 or 011, and an indirect jump with funct3 other than 000 give no redirect, no write and no fault.
- R11: The outputs reflect the instruction presented with `valid_i` high at the previous rising edge. When `valid_i` was low at that edge, the three flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Instruction inputs are valid this cycle |
| instr_i | input | 32 | Instruction word |
| pc_i | input | XLEN | Address of the instruction |
| opa_i | input | XLEN | First source operand value |
| opb_i | input | XLEN | Second source operand value |
| redirect_o | output | 1 | Control moves to `target_o` |
| target_o | output | XLEN | Resolved target address |
| wr_en_o | output | 1 | Write return address to a register |
| wr_idx_o | output | 5 | Destination register index |
| wr_data_o | output | XLEN | Return address value |
| fault_o | output | 1 | Fetch-misalignment fault |
| fault_addr_o | output | XLEN | Target address that faulted |

## Verification
The assertions assume that the output data fields are read only while their flag is high. They also assume that `pc_i` is held for the single cycle its strobe is sampled, so a return address can be related to the PC one edge earlier. The bench drives every instruction with its strobe for exactly one cycle and returns to idle between scenarios. It only compares `target_o`, `wr_data_o` and `fault_addr_o` when the matching flag is expected high. It sets operands and offsets so that every comparison and alignment outcome is known before the edge.

// File: rtl/ctl_xfer_pkg.sv
package ctl_xfer_pkg;

  localparam int unsigned ILEN_BYTES = 4;
  localparam int unsigned RIDX_W     = 5;

  localparam logic [6:0] OPC_BRANCH = 7'b1100011;
  localparam logic [6:0] OPC_JUMP   = 7'b1101111;
  localparam logic [6:0] OPC_JUMPR  = 7'b1100111;

  typedef enum logic [1:0] {
    XFER_NONE   = 2'd0,
    XFER_BRANCH = 2'd1,
    XFER_JUMP   = 2'd2,
    XFER_JUMPR  = 2'd3
  } xfer_kind_e;

  // Condition codes match the funct3 field value.
  typedef enum logic [2:0] {
    CMP_EQ  = 3'b000,
    CMP_NE  = 3'b001,
    CMP_R2  = 3'b010,
    CMP_R3  = 3'b011,
    CMP_LT  = 3'b100,
    CMP_GE  = 3'b101,
    CMP_LTU = 3'b110,
    CMP_GEU = 3'b111
  } cmp_op_e;

endpackage

// File: rtl/ctl_xfer_decode.sv
module ctl_xfer_decode
  import ctl_xfer_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic [31:0]       instr_i,
  output xfer_kind_e        kind_o,
  output cmp_op_e           cmp_o,
  output logic [XLEN-1:0]   imm_o,
  output logic [RIDX_W-1:0] rd_o
);

  logic [6:0]      opcode;
  logic [2:0]      fn3;
  logic [XLEN-1:0] imm_br;
  logic [XLEN-1:0] imm_jp;
  logic [XLEN-1:0] imm_ir;

  assign opcode = instr_i[6:0];
  assign fn3    = instr_i[14:12];
  assign rd_o   = instr_i[11:7];
  assign cmp_o  = cmp_op_e'(fn3);

  // Scattered offset fields gathered back into place.
  assign imm_br = {{(XLEN-12){instr_i[31]}}, instr_i[7], instr_i[30:25],
                   instr_i[11:8], 1'b0};
  assign imm_jp = {{(XLEN-20){instr_i[31]}}, instr_i[19:12], instr_i[20],
                   instr_i[30:21], 1'b0};
  assign imm_ir = {{(XLEN-12){instr_i[31]}}, instr_i[31:20]};

  always_comb begin
    kind_o = XFER_NONE;
    imm_o  = imm_ir;
    unique case (opcode)
      OPC_BRANCH: begin
        imm_o = imm_br;
        if (fn3[2:1] != 2'b01) kind_o = XFER_BRANCH;
      end
      OPC_JUMP: begin
        imm_o  = imm_jp;
        kind_o = XFER_JUMP;
      end
      OPC_JUMPR: begin
        if (fn3 == 3'b000) kind_o = XFER_JUMPR;
      end
      default: kind_o = XFER_NONE;
    endcase
  end

endmodule

// File: rtl/ctl_xfer_compare.sv
module ctl_xfer_compare
  import ctl_xfer_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  cmp_op_e         cmp_i,
  input  logic [XLEN-1:0] opa_i,
  input  logic [XLEN-1:0] opb_i,
  output logic            hold_o
);

  logic is_eq;
  logic is_lt_s;
  logic is_lt_u;

  assign is_eq   = (opa_i == opb_i);
  assign is_lt_s = ($signed(opa_i) < $signed(opb_i));
  assign is_lt_u = (opa_i < opb_i);

  always_comb begin
    unique case (cmp_i)
      CMP_EQ:  hold_o = is_eq;
      CMP_NE:  hold_o = !is_eq;
      CMP_LT:  hold_o = is_lt_s;
      CMP_GE:  hold_o = !is_lt_s;
      CMP_LTU: hold_o = is_lt_u;
      CMP_GEU: hold_o = !is_lt_u;
      default: hold_o = 1'b0;
    endcase
  end

endmodule

// File: rtl/ctl_xfer_target.sv
module ctl_xfer_target #(
  parameter int unsigned XLEN           = 32,
  parameter bit          HAS_COMPRESSED = 1'b0
) (
  input  logic [XLEN-1:0] base_i,
  input  logic [XLEN-1:0] imm_i,
  input  logic            clr_lsb_i,
  output logic [XLEN-1:0] tgt_o,
  output logic            misal_o
);

  logic [XLEN-1:0] sum;

  assign sum   = base_i + imm_i;
  assign tgt_o = {sum[XLEN-1:1], sum[0] & ~clr_lsb_i};

  generate
    if (HAS_COMPRESSED) begin : g_half_align
      assign misal_o = 1'b0;
    end else begin : g_word_align
      assign misal_o = tgt_o[1];
    end
  endgenerate

endmodule

// File: rtl/ctl_xfer_resolve.sv
module ctl_xfer_resolve
  import ctl_xfer_pkg::*;
#(
  parameter int unsigned XLEN           = 32,
  parameter bit          HAS_COMPRESSED = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [31:0]       instr_i,
  input  logic [XLEN-1:0]   pc_i,
  input  logic [XLEN-1:0]   opa_i,
  input  logic [XLEN-1:0]   opb_i,
  output logic              redirect_o,
  output logic [XLEN-1:0]   target_o,
  output logic              wr_en_o,
  output logic [RIDX_W-1:0] wr_idx_o,
  output logic [XLEN-1:0]   wr_data_o,
  output logic              fault_o,
  output logic [XLEN-1:0]   fault_addr_o
);

  localparam logic [XLEN-1:0] LINK_STEP = XLEN'(ILEN_BYTES);

  xfer_kind_e        kind;
  cmp_op_e           cmp;
  logic [XLEN-1:0]   imm;
  logic [RIDX_W-1:0] rd;
  logic              cond_hold;
  logic [XLEN-1:0]   tgt;
  logic              misal;
  logic [XLEN-1:0]   base;
  logic              is_jump;
  logic              taken;

  logic              redirect_d, redirect_q;
  logic              wr_en_d,    wr_en_q;
  logic              fault_d,    fault_q;
  logic [XLEN-1:0]   tgt_d,      tgt_q;
  logic [XLEN-1:0]   link_d,     link_q;
  logic [RIDX_W-1:0] rd_d,       rd_q;

  ctl_xfer_decode #(.XLEN(XLEN)) i_decode (
    .instr_i (instr_i),
    .kind_o  (kind),
    .cmp_o   (cmp),
    .imm_o   (imm),
    .rd_o    (rd)
  );

  ctl_xfer_compare #(.XLEN(XLEN)) i_compare (
    .cmp_i  (cmp),
    .opa_i  (opa_i),
    .opb_i  (opb_i),
    .hold_o (cond_hold)
  );

  assign base    = (kind == XFER_JUMPR) ? opa_i : pc_i;
  assign is_jump = (kind == XFER_JUMP) || (kind == XFER_JUMPR);

  ctl_xfer_target #(.XLEN(XLEN), .HAS_COMPRESSED(HAS_COMPRESSED)) i_target (
    .base_i    (base),
    .imm_i     (imm),
    .clr_lsb_i (kind == XFER_JUMPR),
    .tgt_o     (tgt),
    .misal_o   (misal)
  );

  always_comb begin
    taken      = is_jump || ((kind == XFER_BRANCH) && cond_hold);
    fault_d    = valid_i && taken && misal;
    redirect_d = valid_i && taken && !misal;
    wr_en_d    = valid_i && is_jump && !misal && (rd != '0);
    tgt_d      = tgt;
    link_d     = pc_i + LINK_STEP;
    rd_d       = rd;
  end

  // Flags: updated every cycle.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      redirect_q <= 1'b0;
      wr_en_q    <= 1'b0;
      fault_q    <= 1'b0;
    end else begin
      redirect_q <= redirect_d;
      wr_en_q    <= wr_en_d;
      fault_q    <= fault_d;
    end
  end

  // Payload: loaded only on a valid instruction.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tgt_q  <= '0;
      link_q <= '0;
      rd_q   <= '0;
    end else if (valid_i) begin
      tgt_q  <= tgt_d;
      link_q <= link_d;
      rd_q   <= rd_d;
    end
  end

  assign redirect_o   = redirect_q;
  assign target_o     = tgt_q;
  assign wr_en_o      = wr_en_q;
  assign wr_idx_o     = rd_q;
  assign wr_data_o    = link_q;
  assign fault_o      = fault_q;
  assign fault_addr_o = tgt_q;

endmodule

// File: rtl/ctl_xfer_resolve_chk.sv
module ctl_xfer_resolve_chk #(
  parameter int unsigned XLEN           = 32,
  parameter bit          HAS_COMPRESSED = 1'b0
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            valid_i,
  input logic [XLEN-1:0] pc_i,
  input logic            redirect_o,
  input logic [XLEN-1:0] target_o,
  input logic            wr_en_o,
  input logic [4:0]      wr_idx_o,
  input logic [XLEN-1:0] wr_data_o,
  input logic            fault_o,
  input logic [XLEN-1:0] fault_addr_o
);

  assert_fault_blocks_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> (!redirect_o && !wr_en_o));

  assert_fault_addr_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> (!HAS_COMPRESSED && fault_addr_o[1]));

  assert_redirect_aligned_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (redirect_o && !HAS_COMPRESSED) |-> (target_o[1:0] == 2'b00));

  assert_lsb_clear_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    redirect_o |-> !target_o[0]);

  assert_no_x0_write_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> (wr_idx_o != 5'd0));

  assert_write_has_redirect_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> redirect_o);

  assert_link_value_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> (wr_data_o == $past(pc_i) + XLEN'(4)));

  assert_idle_quiet_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(valid_i) |-> (!redirect_o && !wr_en_o && !fault_o));

endmodule

bind ctl_xfer_resolve ctl_xfer_resolve_chk #(
  .XLEN(XLEN), .HAS_COMPRESSED(HAS_COMPRESSED)
) i_ctl_xfer_resolve_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .valid_i      (valid_i),
  .pc_i         (pc_i),
  .redirect_o   (redirect_o),
  .target_o     (target_o),
  .wr_en_o      (wr_en_o),
  .wr_idx_o     (wr_idx_o),
  .wr_data_o    (wr_data_o),
  .fault_o      (fault_o),
  .fault_addr_o (fault_addr_o)
);

// File: tb/test_ctl_xfer_resolve.sv
`timescale 1ns/1ps
module test_ctl_xfer_resolve;

  logic        clk;
  logic        rst_n;
  logic        valid;
  logic [31:0] instr;
  logic [31:0] pc;
  logic [31:0] opa;
  logic [31:0] opb;
  logic        redirect;
  logic [31:0] target;
  logic        wr_en;
  logic [4:0]  wr_idx;
  logic [31:0] wr_data;
  logic        fault;
  logic [31:0] fault_addr;

  int n_chk  = 0;
  int n_fail = 0;

  ctl_xfer_resolve #(.XLEN(32), .HAS_COMPRESSED(1'b0)) i_ctl_xfer_resolve (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .valid_i      (valid),
    .instr_i      (instr),
    .pc_i         (pc),
    .opa_i        (opa),
    .opb_i        (opb),
    .redirect_o   (redirect),
    .target_o     (target),
    .wr_en_o      (wr_en),
    .wr_idx_o     (wr_idx),
    .wr_data_o    (wr_data),
    .fault_o      (fault),
    .fault_addr_o (fault_addr)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [31:0] enc_br(input logic [12:0] off, input logic [2:0] f3);
    return {off[12], off[10:5], 5'd2, 5'd1, f3, off[4:1], off[11], 7'b1100011};
  endfunction

  function automatic logic [31:0] enc_jp(input logic [20:0] off, input logic [4:0] rd);
    return {off[20], off[10:1], off[11], off[19:12], rd, 7'b1101111};
  endfunction

  function automatic logic [31:0] enc_jr(input logic [11:0] imm, input logic [2:0] f3,
                                         input logic [4:0] rd);
    return {imm, 5'd1, f3, rd, 7'b1100111};
  endfunction

  task automatic check(input string tag, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, got, exp);
    end
  endtask

  // Drive one instruction for one cycle, then sample after the capturing edge.
  task automatic issue(input logic [31:0] i, input logic [31:0] p,
                       input logic [31:0] a, input logic [31:0] b);
    @(negedge clk);
    instr = i; pc = p; opa = a; opb = b; valid = 1'b1;
    @(negedge clk);
    valid = 1'b0;
  endtask

  task automatic expect_out(input string tag, input logic e_redir, input logic e_wr,
                            input logic e_fault, input logic [31:0] e_addr,
                            input logic [4:0] e_idx, input logic [31:0] e_link);
    check(tag, "redirect", {31'd0, redirect}, {31'd0, e_redir});
    check(tag, "wr_en",    {31'd0, wr_en},    {31'd0, e_wr});
    check(tag, "fault",    {31'd0, fault},    {31'd0, e_fault});
    if (e_redir) check(tag, "target", target, e_addr);
    if (e_fault) check(tag, "fault_addr", fault_addr, e_addr);
    if (e_wr) begin
      check(tag, "wr_idx", {27'd0, wr_idx}, {27'd0, e_idx});
      check(tag, "wr_data", wr_data, e_link);
    end
  endtask

  task automatic t_reset_R1;
    rst_n = 1'b0; valid = 1'b0; instr = '0; pc = '0; opa = '0; opb = '0;
    repeat (3) @(negedge clk);
    expect_out("R1", 1'b0, 1'b0, 1'b0, '0, '0, '0);
    rst_n = 1'b1;
    @(negedge clk);
    expect_out("R1", 1'b0, 1'b0, 1'b0, '0, '0, '0);
  endtask

  task automatic t_conditions_R2;
    // A = -1, B = 1: signed A<B, unsigned A>B. Offset -8 from 0x1000.
    issue(enc_br(13'h1FF8, 3'b000), 32'h1000, 32'hFFFF_FFFF, 32'd1);
    expect_out("R2 eq-false", 1'b0, 1'b0, 1'b0, 32'h0FF8, '0, '0);
    issue(enc_br(13'h1FF8, 3'b001), 32'h1000, 32'hFFFF_FFFF, 32'd1);
    expect_out("R2 ne-true", 1'b1, 1'b0, 1'b0, 32'h0FF8, '0, '0);
    issue(enc_br(13'h1FF8, 3'b100), 32'h1000, 32'hFFFF_FFFF, 32'd1);
    expect_out("R2 lt-true", 1'b1, 1'b0, 1'b0, 32'h0FF8, '0, '0);
    issue(enc_br(13'h1FF8, 3'b101), 32'h1000, 32'hFFFF_FFFF, 32'd1);
    expect_out("R2 ge-false", 1'b0, 1'b0, 1'b0, 32'h0FF8, '0, '0);
    issue(enc_br(13'h1FF8, 3'b110), 32'h1000, 32'hFFFF_FFFF, 32'd1);
    expect_out("R2 ltu-false", 1'b0, 1'b0, 1'b0, 32'h0FF8, '0, '0);
    issue(enc_br(13'h1FF8, 3'b111), 32'h1000, 32'hFFFF_FFFF, 32'd1);
    expect_out("R2 geu-true", 1'b1, 1'b0, 1'b0, 32'h0FF8, '0, '0);
    // Equal operands.
    issue(enc_br(13'h1FF8, 3'b000), 32'h1000, 32'h55, 32'h55);
    expect_out("R2 eq-true", 1'b1, 1'b0, 1'b0, 32'h0FF8, '0, '0);
    issue(enc_br(13'h1FF8, 3'b101), 32'h1000, 32'h55, 32'h55);
    expect_out("R2 ge-equal", 1'b1, 1'b0, 1'b0, 32'h0FF8, '0, '0);
    issue(enc_br(13'h1FF8, 3'b110), 32'h1000, 32'h55, 32'h55);
    expect_out("R2 ltu-equal", 1'b0, 1'b0, 1'b0, 32'h0FF8, '0, '0);
  endtask

  task automatic t_branch_offset_R3;
    issue(enc_br(13'h0A4C, 3'b000), 32'h1000, 32'd7, 32'd7);
    expect_out("R3 pos", 1'b1, 1'b0, 1'b0, 32'h1A4C, '0, '0);
    issue(enc_br(13'h1000, 3'b000), 32'h2000, 32'd7, 32'd7);
    expect_out("R3 most-neg", 1'b1, 1'b0, 1'b0, 32'h1000, '0, '0);
    issue(enc_br(13'h07FC, 3'b000), 32'h0, 32'd7, 32'd7);
    expect_out("R3 low-bits", 1'b1, 1'b0, 1'b0, 32'h07FC, '0, '0);
  endtask

  task automatic t_jump_R4;
    issue(enc_jp(21'h081A3C, 5'd5), 32'h100, 32'hDEAD, 32'hBEEF);
    expect_out("R4 pos", 1'b1, 1'b1, 1'b0, 32'h0008_1B3C, 5'd5, 32'h104);
    issue(enc_jp(21'h1FFFFC, 5'd31), 32'h100, '0, '0);
    expect_out("R4 neg", 1'b1, 1'b1, 1'b0, 32'h0000_00FC, 5'd31, 32'h104);
    issue(enc_jp(21'h100000, 5'd3), 32'h0020_0000, '0, '0);
    expect_out("R4 most-neg", 1'b1, 1'b1, 1'b0, 32'h0010_0000, 5'd3, 32'h0020_0004);
  endtask

  task automatic t_jumpr_R5;
    issue(enc_jr(12'h7FF, 3'b000, 5'd1), 32'h8000, 32'h3001, '0);
    expect_out("R5 pos", 1'b1, 1'b1, 1'b0, 32'h3800, 5'd1, 32'h8004);
    issue(enc_jr(12'h005, 3'b000, 5'd9), 32'h8000, 32'h4000, '0);
    expect_out("R5 lsb-clear", 1'b1, 1'b1, 1'b0, 32'h4004, 5'd9, 32'h8004);
    issue(enc_jr(12'hFF8, 3'b000, 5'd2), 32'h8000, 32'h4000, '0);
    expect_out("R5 neg", 1'b1, 1'b1, 1'b0, 32'h3FF8, 5'd2, 32'h8004);
  endtask

  task automatic t_link_R6;
    issue(enc_jp(21'h000010, 5'd12), 32'hFFFF_FFF0, '0, '0);
    expect_out("R6 wrap", 1'b1, 1'b1, 1'b0, 32'h0000_0000, 5'd12, 32'hFFFF_FFF4);
  endtask

  task automatic t_x0_R7;
    issue(enc_jp(21'h000040, 5'd0), 32'h200, '0, '0);
    expect_out("R7 jump", 1'b1, 1'b0, 1'b0, 32'h240, '0, '0);
    issue(enc_jr(12'h010, 3'b000, 5'd0), 32'h200, 32'h600, '0);
    expect_out("R7 jumpr", 1'b1, 1'b0, 1'b0, 32'h610, '0, '0);
  endtask

  task automatic t_misalign_R8;
    issue(enc_br(13'h0006, 3'b000), 32'h1000, 32'd4, 32'd4);
    expect_out("R8 branch", 1'b0, 1'b0, 1'b1, 32'h1006, '0, '0);
    issue(enc_jp(21'h000022, 5'd4), 32'h1000, '0, '0);
    expect_out("R8 jump", 1'b0, 1'b0, 1'b1, 32'h1022, '0, '0);
    issue(enc_jr(12'h006, 3'b000, 5'd4), 32'h1000, 32'h4000, '0);
    expect_out("R8 jumpr", 1'b0, 1'b0, 1'b1, 32'h4006, '0, '0);
    issue(enc_jr(12'h003, 3'b000, 5'd4), 32'h1000, 32'h4000, '0);
    expect_out("R8 jumpr-b1", 1'b0, 1'b0, 1'b1, 32'h4002, '0, '0);
  endtask

  task automatic t_not_taken_R9;
    issue(enc_br(13'h0006, 3'b001), 32'h1000, 32'd4, 32'd4);
    expect_out("R9 ne", 1'b0, 1'b0, 1'b0, '0, '0, '0);
    issue(enc_br(13'h1FFA, 3'b100), 32'h1000, 32'd9, 32'd4);
    expect_out("R9 lt", 1'b0, 1'b0, 1'b0, '0, '0, '0);
  endtask

  task automatic t_unknown_R10;
    issue(enc_br(13'h0008, 3'b010), 32'h1000, 32'd4, 32'd4);
    expect_out("R10 br-f3-010", 1'b0, 1'b0, 1'b0, '0, '0, '0);
    issue(enc_br(13'h0008, 3'b011), 32'h1000, 32'd4, 32'd5);
    expect_out("R10 br-f3-011", 1'b0, 1'b0, 1'b0, '0, '0, '0);
    issue(enc_jr(12'h010, 3'b001, 5'd6), 32'h1000, 32'h4000, '0);
    expect_out("R10 jumpr-f3", 1'b0, 1'b0, 1'b0, '0, '0, '0);
    issue({12'h010, 5'd1, 3'b000, 5'd6, 7'b0010011}, 32'h1000, 32'h4000, '0);
    expect_out("R10 alu", 1'b0, 1'b0, 1'b0, '0, '0, '0);
  endtask

  task automatic t_valid_R11;
    @(negedge clk);
    instr = enc_jp(21'h000040, 5'd7); pc = 32'h300; valid = 1'b0;
    @(negedge clk);
    expect_out("R11 no-strobe", 1'b0, 1'b0, 1'b0, '0, '0, '0);
    // Back-to-back strobes: each result appears one cycle later.
    @(negedge clk);
    instr = enc_jp(21'h000040, 5'd7); pc = 32'h300; valid = 1'b1;
    @(negedge clk);
    expect_out("R11 first", 1'b1, 1'b1, 1'b0, 32'h340, 5'd7, 32'h304);
    instr = enc_br(13'h0006, 3'b000); pc = 32'h500; opa = 32'd1; opb = 32'd1;
    @(negedge clk);
    valid = 1'b0;
    expect_out("R11 second", 1'b0, 1'b0, 1'b1, 32'h506, '0, '0);
    @(negedge clk);
    expect_out("R11 idle", 1'b0, 1'b0, 1'b0, '0, '0, '0);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL R11 watchdog: actual hung expected finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin : main
    t_reset_R1();
    t_conditions_R2();
    t_branch_offset_R3();
    t_jump_R4();
    t_jumpr_R5();
    t_link_R6();
    t_x0_R7();
    t_misalign_R8();
    t_not_taken_R9();
    t_unknown_R10();
    t_valid_R11();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule